// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Gate Sequencer

This block turns one PWM command into enable signals for the upper and lower switches of a synchronous buck half-bridge. The two enables are never on together. The gap between one switch turning off and the other turning on is not a fixed delay. The sequencer waits for comparator feedback first: a flag that the lower-gate voltage has dropped below its threshold, or a flag that the switch node has dropped below its threshold.

The PWM command arrives already decoded into three levels: low, high, or inside a mid-level shutdown window. A command that stays in the window for a programmable holdoff parks both switches off. A supply-good flag, with hysteresis already applied outside the block, keeps both gates off whenever it is false. While the lower switch is on, the block also watches the switch node. If the node stays high for a programmable filter time, the block treats it as a fault and keeps both gates off until the next PWM rising edge.

All inputs pass through a synchronizer of `SYNC_STAGES` flops before the state register sees them. The holdoff and fault filter are counted in clock cycles.

Top module: `hb_deadtime_seq`

## Requirements
- R1: While `supply_ok` is 0, `ug_en` and `lg_en` are both 0 and `pwm_lvl` has no effect on them.
- R2: When `supply_ok` falls, both enables are 0 three cycles later. When it returns, normal sequencing resumes and a low command turns the lower gate back on.
- R3: `pwm_lvl` = 2'b01 (high) turns `lg_en` off three cycles after the change. `ug_en` stays 0 until `lg_low` is 1, and rises three cycles after `lg_low` rises.
- R4: `pwm_lvl` = 2'b00 (low) turns `ug_en` off three cycles after the change. `lg_en` stays 0 until `sw_low` is 1, and rises three cycles after `sw_low` rises.
- R5: `pwm_lvl[1]` = 1 (mid window, 2'b10 or 2'b11) held for `HOLDOFF_CYC` consecutive sampled cycles forces both enables to 0, exactly `HOLDOFF_CYC`+2 cycles after the command enters the window.
- R6: Once the command leaves the window, the high/low level again selects which gate is driven, with the same feedback gating as R3 and R4.
- R7: The holdoff count restarts whenever the command leaves the window before the count completes.
- R8: While the lower gate is on, `sw_low` = 0 held for `FAULT_CYC` consecutive sampled cycles turns `lg_en` off `FAULT_CYC`+2 cycles after `sw_low` fell. A shorter excursion has no effect.
- R9: After an R8 fault, both enables stay 0 through low or mid commands and through switch-node changes, until `pwm_lvl` enters high.
- R10: If the command reverses while the block waits in a break interval that began by turning a gate off, that gate turns back on without waiting for feedback. If the break began from shutdown, the opposite feedback wait applies instead.
- R11: `ug_en` and `lg_en` are 0 after reset and are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_lvl | input | 2 | Decoded PWM level: 00 low, 01 high, 1x mid window |
| supply_ok | input | 1 | Supply-good flag with hysteresis |
| lg_low | input | 1 | Lower-gate voltage below its turn-off threshold |
| sw_low | input | 1 | Switch-node voltage below its threshold |
| ug_en | output | 1 | Upper gate enable, registered |
| lg_en | output | 1 | Lower gate enable, registered |

## Verification
Every input goes through two synchronizer flops and then the state register, so any response that depends on a single cycle is due on the third rising edge after the input changes. The holdoff and fault results are due `HOLDOFF_CYC`+2 and `FAULT_CYC`+2 edges after their triggering change. The bench drives inputs and samples outputs 1 ns after a rising edge. It counts edges from each stimulus and checks the output both on the edge before the due edge and on the due edge itself, so an off-by-one in either direction is caught. The holdoff is swept over every window length from 1 to `HOLDOFF_CYC`+2, cycle by cycle.

// File: rtl/hbd_pkg.sv
`timescale 1ns/1ps
package hbd_pkg;
   typedef enum logic [1:0] {
      PWM_LOW     = 2'b00,
      PWM_HIGH    = 2'b01,
      PWM_MID     = 2'b10,
      PWM_MID_ALT = 2'b11
   } pwm_lvl_e;

   typedef enum logic [2:0] {
      ST_OFF,
      ST_LOW_ON,
      ST_BREAK_LOW,
      ST_HIGH_ON,
      ST_BREAK_HIGH,
      ST_TRISTATE,
      ST_FAULT
   } seq_state_e;

   function automatic logic lvl_is_mid(input logic [1:0] lvl);
      return lvl[1];
   endfunction

   function automatic logic lvl_is_high(input logic [1:0] lvl);
      return lvl == PWM_HIGH;
   endfunction

   function automatic logic lvl_is_low(input logic [1:0] lvl);
      return lvl == PWM_LOW;
   endfunction
endpackage

// File: rtl/hbd_sync.sv
`timescale 1ns/1ps
module hbd_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hbd_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("hbd_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/hbd_run_timer.sv
`timescale 1ns/1ps
module hbd_run_timer #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   if (LIMIT < 1) begin : g_bad_limit
      $error("hbd_run_timer: LIMIT must be at least 1");
   end

   localparam int            CW   = (LIMIT > 1) ? $clog2(LIMIT) : 1;
   localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!run)        cnt <= '0;
      else if (cnt != LAST) cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt == LAST);

   AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !expired || $past(LIMIT == 1)) else $error("timer restart");  // R7
endmodule

// File: rtl/hb_deadtime_seq.sv
`timescale 1ns/1ps
module hb_deadtime_seq #(
   parameter int SYNC_STAGES = 2,
   parameter int HOLDOFF_CYC = 23,
   parameter int FAULT_CYC   = 200
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] pwm_lvl,
   input  logic       supply_ok,
   input  logic       lg_low,
   input  logic       sw_low,
   output logic       ug_en,
   output logic       lg_en
);
   import hbd_pkg::*;

   localparam int SYNC_W = 5;

   if (HOLDOFF_CYC < 1) begin : g_bad_holdoff
      $error("hb_deadtime_seq: HOLDOFF_CYC must be at least 1");
   end
   if (FAULT_CYC < 1) begin : g_bad_fault
      $error("hb_deadtime_seq: FAULT_CYC must be at least 1");
   end

   logic [SYNC_W-1:0] sync_q;
   logic [1:0]        s_pwm, prev_pwm;
   logic              s_sup, s_lg_low, s_sw_low;

   hbd_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({supply_ok, lg_low, sw_low, pwm_lvl}),
      .q     (sync_q)
   );
   assign {s_sup, s_lg_low, s_sw_low, s_pwm} = sync_q;

   seq_state_e st, nxt;
   logic       rev_ok, nxt_rev;
   logic       hold_exp, fault_exp, pwm_rise;

   hbd_run_timer #(.LIMIT(HOLDOFF_CYC)) u_holdoff (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (lvl_is_mid(s_pwm)),
      .expired (hold_exp)
   );

   hbd_run_timer #(.LIMIT(FAULT_CYC)) u_fault_flt (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     ((st == ST_LOW_ON) && !s_sw_low),
      .expired (fault_exp)
   );

   assign pwm_rise = lvl_is_high(s_pwm) && !lvl_is_high(prev_pwm);

   always_comb begin
      nxt = st;
      if (!s_sup) begin
         nxt = ST_OFF;
      end else begin
         case (st)
            ST_OFF:   nxt = lvl_is_high(s_pwm) ? ST_BREAK_LOW : ST_BREAK_HIGH;
            ST_FAULT: if (pwm_rise) nxt = ST_BREAK_LOW;
            default: begin
               if (st == ST_LOW_ON && fault_exp) begin
                  nxt = ST_FAULT;
               end else if (hold_exp) begin
                  nxt = ST_TRISTATE;
               end else begin
                  case (st)
                     ST_LOW_ON:
                        if (lvl_is_high(s_pwm)) nxt = ST_BREAK_LOW;
                     ST_HIGH_ON:
                        if (lvl_is_low(s_pwm)) nxt = ST_BREAK_HIGH;
                     ST_BREAK_LOW:
                        if (lvl_is_low(s_pwm))
                           nxt = rev_ok ? ST_LOW_ON : ST_BREAK_HIGH;
                        else if (lvl_is_high(s_pwm) && s_lg_low)
                           nxt = ST_HIGH_ON;
                     ST_BREAK_HIGH:
                        if (lvl_is_high(s_pwm))
                           nxt = rev_ok ? ST_HIGH_ON : ST_BREAK_LOW;
                        else if (lvl_is_low(s_pwm) && s_sw_low)
                           nxt = ST_LOW_ON;
                     ST_TRISTATE:
                        if (lvl_is_high(s_pwm))     nxt = ST_BREAK_LOW;
                        else if (lvl_is_low(s_pwm)) nxt = ST_BREAK_HIGH;
                     default: nxt = ST_OFF;
                  endcase
               end
            end
         endcase
      end
   end

   assign nxt_rev = ((st == ST_LOW_ON)  && (nxt == ST_BREAK_LOW))  ||
                    ((st == ST_HIGH_ON) && (nxt == ST_BREAK_HIGH)) ||
                    (rev_ok && (nxt == st));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_OFF;
         rev_ok   <= 1'b0;
         prev_pwm <= PWM_LOW;
         ug_en    <= 1'b0;
         lg_en    <= 1'b0;
      end else begin
         st       <= nxt;
         rev_ok   <= nxt_rev;
         prev_pwm <= s_pwm;
         ug_en    <= (nxt == ST_HIGH_ON);
         lg_en    <= (nxt == ST_LOW_ON);
      end
   end

   AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
      !(ug_en && lg_en)) else $error("both gates on");  // R11
   AST_SUPPLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !s_sup |=> !ug_en && !lg_en) else $error("gate on without supply");  // R1
   AST_UPPER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BREAK_LOW && !s_lg_low && !lvl_is_low(s_pwm)) |=> !ug_en)
      else $error("upper on before lower sense");  // R3
   AST_LOWER_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_BREAK_HIGH && !s_sw_low) |=> !lg_en)
      else $error("lower on before node sense");  // R4
   AST_HOLDOFF_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_exp && s_sup && st != ST_FAULT) |=> !ug_en && !lg_en)
      else $error("gate on after holdoff");  // R5
   AST_FAULT_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_exp && s_sup) |=> !lg_en) else $error("lower on after fault");  // R8
   AST_FAULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FAULT && s_sup && !pwm_rise) |=> (st == ST_FAULT))
      else $error("fault cleared early");  // R9
endmodule

// File: tb/hb_deadtime_seq_tb_top.sv
`timescale 1ns/1ps
module hb_deadtime_seq_tb_top;
   localparam int H = 4;
   localparam int F = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pwm_lvl = 2'b00;
   logic       supply_ok = 1'b0;
   logic       lg_low = 1'b1;
   logic       sw_low = 1'b1;
   logic       ug_en, lg_en;

   int checks = 0;
   int fails  = 0;
   bit overlap_seen = 1'b0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   hb_deadtime_seq #(.SYNC_STAGES(2), .HOLDOFF_CYC(H), .FAULT_CYC(F)) dut_i (
      .clk(clk), .rst_n(rst_n), .pwm_lvl(pwm_lvl), .supply_ok(supply_ok),
      .lg_low(lg_low), .sw_low(sw_low), .ug_en(ug_en), .lg_en(lg_en)
   );

   always @(negedge clk) if (rst_n && ug_en && lg_en) overlap_seen = 1'b1;

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input logic got_u, input logic got_l,
                      input logic exp_u, input logic exp_l, input string req);
      checks++;
      if (got_u !== exp_u || got_l !== exp_l) begin
         fails++;
         $display("FAIL %s: ug_en/lg_en = %b%b, expected %b%b at %0t",
                  req, got_u, got_l, exp_u, exp_l, $time);
      end
   endtask

   initial begin
      #500000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk(ug_en, lg_en, 0, 0, "R11 reset");

      // R1: PWM ignored while supply is not good
      for (int i = 0; i < 6; i++) begin
         pwm_lvl = (i % 2 == 0) ? 2'b01 : 2'b00;
         tick(2);
         chk(ug_en, lg_en, 0, 0, "R1");
      end

      // power up with low command
      pwm_lvl = 2'b00; supply_ok = 1'b1;
      tick(4);
      chk(ug_en, lg_en, 0, 1, "R2 power-up low");

      // R3 rising edge
      lg_low = 1'b0; pwm_lvl = 2'b01;
      tick(2); chk(ug_en, lg_en, 0, 1, "R3 before due edge");
      tick(1); chk(ug_en, lg_en, 0, 0, "R3 lower off");
      tick(5); chk(ug_en, lg_en, 0, 0, "R3 waiting sense");
      lg_low = 1'b1;
      tick(2); chk(ug_en, lg_en, 0, 0, "R3 sense in flight");
      tick(1); chk(ug_en, lg_en, 1, 0, "R3 upper on");

      // R4 falling edge
      sw_low = 1'b0; pwm_lvl = 2'b00;
      tick(2); chk(ug_en, lg_en, 1, 0, "R4 before due edge");
      tick(1); chk(ug_en, lg_en, 0, 0, "R4 upper off");
      tick(5); chk(ug_en, lg_en, 0, 0, "R4 waiting sense");
      sw_low = 1'b1;
      tick(2); chk(ug_en, lg_en, 0, 0, "R4 sense in flight");
      tick(1); chk(ug_en, lg_en, 0, 1, "R4 lower on");

      // R10 reversal back to the lower gate
      lg_low = 1'b0; pwm_lvl = 2'b01;
      tick(3); chk(ug_en, lg_en, 0, 0, "R10 break low");
      pwm_lvl = 2'b00;
      tick(2); chk(ug_en, lg_en, 0, 0, "R10 before revert");
      tick(1); chk(ug_en, lg_en, 0, 1, "R10 lower restored");

      // R10 reversal back to the upper gate
      lg_low = 1'b1; pwm_lvl = 2'b01;
      tick(4); chk(ug_en, lg_en, 1, 0, "R10 upper on");
      sw_low = 1'b0; pwm_lvl = 2'b00;
      tick(3); chk(ug_en, lg_en, 0, 0, "R10 break high");
      pwm_lvl = 2'b01;
      tick(2); chk(ug_en, lg_en, 0, 0, "R10 before revert high");
      tick(1); chk(ug_en, lg_en, 1, 0, "R10 upper restored");
      sw_low = 1'b1; pwm_lvl = 2'b00;
      tick(4); chk(ug_en, lg_en, 0, 1, "R4 back to low");

      // R2 supply drop and return
      supply_ok = 1'b0;
      tick(2); chk(ug_en, lg_en, 0, 1, "R2 before due edge");
      tick(1); chk(ug_en, lg_en, 0, 0, "R2 gates forced off");
      pwm_lvl = 2'b01;
      tick(4); chk(ug_en, lg_en, 0, 0, "R2 PWM ignored");
      pwm_lvl = 2'b00; supply_ok = 1'b1;
      tick(6); chk(ug_en, lg_en, 0, 1, "R2 resumed");

      // R5 / R6 holdoff sweep over window length
      for (int k = 1; k <= H + 2; k++) begin
         for (int c = 1; c <= H + 2; c++) begin
            pwm_lvl = (c <= k) ? 2'b10 : 2'b00;
            tick(1);
            chk(ug_en, lg_en, 0, (c == H + 2 && k >= H) ? 1'b0 : 1'b1, "R5 sweep");
         end
         pwm_lvl = 2'b00;
         tick(6);
         chk(ug_en, lg_en, 0, 1, "R6 after window");
      end

      // R7 restart: two short windows separated by one low cycle
      for (int c = 1; c <= 2 * H + 4; c++) begin
         pwm_lvl = (c <= H - 1 || (c >= H + 1 && c <= 2 * H - 1)) ? 2'b11 : 2'b00;
         tick(1);
         chk(ug_en, lg_en, 0, 1, "R7 restart");
      end

      // R6 shutdown then high
      pwm_lvl = 2'b10;
      tick(H + 2); chk(ug_en, lg_en, 0, 0, "R5 shutdown");
      pwm_lvl = 2'b01;
      tick(3); chk(ug_en, lg_en, 0, 0, "R6 break");
      tick(1); chk(ug_en, lg_en, 1, 0, "R6 upper on");

      // R10 no reversal when the break began from shutdown
      pwm_lvl = 2'b10;
      tick(H + 2); chk(ug_en, lg_en, 0, 0, "R5 shutdown from high");
      lg_low = 1'b0; pwm_lvl = 2'b01;
      tick(4); chk(ug_en, lg_en, 0, 0, "R6 waiting lower sense");
      sw_low = 1'b0; pwm_lvl = 2'b00;
      tick(5); chk(ug_en, lg_en, 0, 0, "R10 no revert");
      sw_low = 1'b1; lg_low = 1'b1;
      tick(3); chk(ug_en, lg_en, 0, 1, "R4 lower after sense");

      // R8 short excursion filtered
      sw_low = 1'b0;
      tick(F - 1);
      sw_low = 1'b1;
      for (int c = 0; c < F + 3; c++) begin
         tick(1);
         chk(ug_en, lg_en, 0, 1, "R8 short excursion");
      end

      // R8 fault
      sw_low = 1'b0;
      tick(F + 1); chk(ug_en, lg_en, 0, 1, "R8 before due edge");
      tick(1);     chk(ug_en, lg_en, 0, 0, "R8 fault trip");

      // R9 fault held
      sw_low = 1'b1;
      tick(4); chk(ug_en, lg_en, 0, 0, "R9 node recovered");
      pwm_lvl = 2'b10;
      tick(H + 3); chk(ug_en, lg_en, 0, 0, "R9 mid");
      pwm_lvl = 2'b00;
      tick(4); chk(ug_en, lg_en, 0, 0, "R9 low");
      pwm_lvl = 2'b01;
      tick(3); chk(ug_en, lg_en, 0, 0, "R9 clearing break");
      tick(1); chk(ug_en, lg_en, 1, 0, "R9 cleared by rise");

      checks++;
      if (overlap_seen) begin
         fails++;
         $display("FAIL R11: overlap seen = 1, expected 0");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule